// File: doc/BRIEF.md
# Hypervisor Trap Delegation Unit

This block keeps the hypervisor-level exception delegation register and, for every synchronous trap, chooses which privilege level takes it: machine mode, hypervisor-extended supervisor mode (HS) or the virtual supervisor mode of a guest (VS). The choice is made in two stages. First the machine-level delegation mask, supplied from outside, must pass the trap down from M to HS. Then the trap can go further to VS, but only if the hart was running virtualized and the matching bit of the local register is set.

The register has a simple CSR port. A write lands on the next rising clock edge and a read is combinational. Each bit is either writable or permanently zero. The writable set is fixed and sparse. Bit 0 (misaligned instruction fetch) is writable only when the core's instruction alignment is 32 bits, which a parameter selects. The routing output is combinational and is valid in the same cycle as the trap request.

Top module: `trap_deleg_unit`

## Requirements
- R1: After reset, `csrRdData` reads all zeros.
- R2: Bits 1 to 8, 12, 13 and 15 of the register are writable. When `csrWrEn` is high at a rising edge, those bits take the value of `csrWrData` and are visible on `csrRdData` after that edge. When `csrWrEn` is low, the register keeps its value.
- R3: Bits 9, 10, 11, 14 and 16 to 63 always read as zero, and writes to them have no effect.
- R4: Bit 0 is writable when `IALIGN32` is 1, which is the default. When `IALIGN32` is 0, bit 0 always reads zero.
- R5: When `trapValid` is low, `targetLevel` shows the M code. Level codes are M = 2'b11, HS = 2'b01 and VS = 2'b10. The code 2'b00 is never driven.
- R6: A trap taken while `privLevel` is 2'b11 (machine) goes to M, whatever the delegation bits hold. `privLevel` uses 2'b00 for user and 2'b01 for supervisor.
- R7: A trap whose cause bit is clear in `medelegMask` goes to M.
- R8: A trap delegated by `medelegMask`, taken with `virtMode` low, goes to HS.
- R9: A trap delegated by `medelegMask`, taken with `virtMode` high, goes to VS if the register bit indexed by `trapCause` is set, and to HS if that bit is clear.
- R10: If a trap and a CSR write happen in the same cycle, the trap is routed using the register value from before the write. The new value governs traps from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| csrWrEn | input | 1 | Write strobe for the delegation register |
| csrWrData | input | XLEN | Value to write |
| csrRdData | output | XLEN | Current register value, read-only bits shown as zero |
| medelegMask | input | XLEN | Machine-level exception delegation mask |
| virtMode | input | 1 | Virtualization flag as it was before the trap |
| privLevel | input | 2 | Privilege level before the trap (11 = M, 01 = S, 00 = U) |
| trapValid | input | 1 | A synchronous trap is being taken this cycle |
| trapCause | input | CAUSE_W | Exception cause code, used as the bit index |
| targetLevel | output | 2 | Level that handles the trap (11 = M, 01 = HS, 10 = VS) |

## Verification
A CSR write and a trap lookup can happen in the same cycle, and the routing must use the register contents from before the write. The bench first sets the bit for a cause, then raises a trap on that cause together with a write that clears the bit. Before the edge it expects VS. After the edge, with the same trap still presented, it expects HS. A second case runs the other way round: a write that sets a bit in the same cycle as the trap must not change the routing until after the edge.

// File: rtl/trap_deleg_pkg.sv
package trap_deleg_pkg;

  typedef enum logic [1:0] {
    LVL_HS = 2'b01,
    LVL_VS = 2'b10,
    LVL_M  = 2'b11
  } lvl_e;

  localparam logic [1:0] PRIV_M = 2'b11;

  // strobes from control to datapath
  typedef struct packed {
    logic wrStb;
    logic lookupEn;
  } deleg_ctl_t;

  // fixed sparse set of implemented register bits
  function automatic bit isWritable(int idx, bit ialign32);
    return (idx == 0 && ialign32) || (idx >= 1 && idx <= 8) ||
           idx == 12 || idx == 13 || idx == 15;
  endfunction

endpackage

// File: rtl/trap_deleg_regs.sv
module trap_deleg_regs
  import trap_deleg_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter bit IALIGN32 = 1'b1,
  parameter int CAUSE_W  = $clog2(XLEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  deleg_ctl_t         ctl,
  input  logic [XLEN-1:0]    wrData,
  input  logic [XLEN-1:0]    medelegMask,
  input  logic [CAUSE_W-1:0] causeIdx,
  output logic [XLEN-1:0]    rdData,
  output logic               mBit,
  output logic               hBit
);

  localparam int IDX_RANGE = 1 << CAUSE_W;

  logic [XLEN-1:0] wrMask;

  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    if (isWritable(i, IALIGN32)) begin : g_rw
      logic bitQ;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          bitQ <= 1'b0;
        else if (ctl.wrStb)  bitQ <= wrData[i];
      end
      assign rdData[i] = bitQ;
      assign wrMask[i] = 1'b1;
    end else begin : g_ro
      assign rdData[i] = 1'b0;
      assign wrMask[i] = 1'b0;
    end
  end

  // bit lookup for the trap cause, out-of-range cause reads as zero
  logic [IDX_RANGE-1:0] mExt, hExt;
  always_comb begin
    mExt = '0;
    hExt = '0;
    mExt[XLEN-1:0] = medelegMask;
    hExt[XLEN-1:0] = rdData;
  end

  assign mBit = ctl.lookupEn & mExt[causeIdx];
  assign hBit = ctl.lookupEn & hExt[causeIdx];

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.wrStb |=> ((rdData & wrMask) == ($past(wrData) & wrMask)));

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.wrStb |=> $stable(rdData));

endmodule

// File: rtl/trap_deleg_ctrl.sv
module trap_deleg_ctrl
  import trap_deleg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csrWrEn,
  input  logic       trapValid,
  input  logic       virtMode,
  input  logic [1:0] privLevel,
  input  logic       mBit,
  input  logic       hBit,
  output deleg_ctl_t ctl,
  output logic [1:0] targetLevel
);

  lvl_e levelSel;

  always_comb begin
    ctl.wrStb    = csrWrEn;
    ctl.lookupEn = trapValid;
  end

  always_comb begin
    levelSel = LVL_M;
    if (trapValid && privLevel != PRIV_M && mBit) begin
      if (virtMode && hBit) levelSel = LVL_VS;
      else                  levelSel = LVL_HS;
    end
  end

  assign targetLevel = levelSel;

  a_r5_idle_is_m: assert property (@(posedge clk) disable iff (!rst_n)
    !trapValid |-> targetLevel == LVL_M);

  a_r5_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    targetLevel != 2'b00);

  a_r6_m_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (trapValid && privLevel == PRIV_M) |-> targetLevel == LVL_M);

  a_r7_no_mach_deleg: assert property (@(posedge clk) disable iff (!rst_n)
    (trapValid && !mBit) |-> targetLevel == LVL_M);

  a_r9_vs_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
    targetLevel == LVL_VS |-> (virtMode && mBit && hBit));

endmodule

// File: rtl/trap_deleg_unit.sv
module trap_deleg_unit
  import trap_deleg_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter bit IALIGN32 = 1'b1,
  parameter int CAUSE_W  = $clog2(XLEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csrWrEn,
  input  logic [XLEN-1:0]    csrWrData,
  output logic [XLEN-1:0]    csrRdData,
  input  logic [XLEN-1:0]    medelegMask,
  input  logic               virtMode,
  input  logic [1:0]         privLevel,
  input  logic               trapValid,
  input  logic [CAUSE_W-1:0] trapCause,
  output logic [1:0]         targetLevel
);

  deleg_ctl_t ctl;
  logic       mBit, hBit;

  trap_deleg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .csrWrEn(csrWrEn), .trapValid(trapValid),
    .virtMode(virtMode), .privLevel(privLevel), .mBit(mBit), .hBit(hBit),
    .ctl(ctl), .targetLevel(targetLevel)
  );

  trap_deleg_regs #(.XLEN(XLEN), .IALIGN32(IALIGN32), .CAUSE_W(CAUSE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wrData(csrWrData),
    .medelegMask(medelegMask), .causeIdx(trapCause),
    .rdData(csrRdData), .mBit(mBit), .hBit(hBit)
  );

endmodule

// File: tb/trap_deleg_unit_test.sv
module trap_deleg_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csrWrEn = 1'b0;
  logic [63:0] csrWrData = '0;
  logic [63:0] csrRdData, rdHalf;
  logic [63:0] medelegMask = '0;
  logic        virtMode = 1'b0;
  logic [1:0]  privLevel = 2'b00;
  logic        trapValid = 1'b0;
  logic [5:0]  trapCause = '0;
  logic [1:0]  targetLevel, tgtHalf;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trap_deleg_unit uut (
    .clk(clk), .rst_n(rst_n), .csrWrEn(csrWrEn), .csrWrData(csrWrData),
    .csrRdData(csrRdData), .medelegMask(medelegMask), .virtMode(virtMode),
    .privLevel(privLevel), .trapValid(trapValid), .trapCause(trapCause),
    .targetLevel(targetLevel)
  );

  trap_deleg_unit #(.IALIGN32(1'b0)) uutHalf (
    .clk(clk), .rst_n(rst_n), .csrWrEn(csrWrEn), .csrWrData(csrWrData),
    .csrRdData(rdHalf), .medelegMask(medelegMask), .virtMode(virtMode),
    .privLevel(privLevel), .trapValid(trapValid), .trapCause(trapCause),
    .targetLevel(tgtHalf)
  );

  // {trapValid, privLevel, virtMode, trapCause, expected level}
  // medeleg bits: 0,1,2,4,5,6,7,12,13,15,20 ; register bits: 0,2,4,5,6,7,13,15
  localparam logic [11:0] VEC [12] = '{
    {1'b1, 2'd0, 1'b1, 6'd2,  2'b10},  // R9 VS
    {1'b1, 2'd0, 1'b0, 6'd2,  2'b01},  // R8 HS
    {1'b1, 2'd1, 1'b1, 6'd1,  2'b01},  // R9 hv bit clear
    {1'b1, 2'd0, 1'b1, 6'd3,  2'b11},  // R7
    {1'b1, 2'd3, 1'b0, 6'd2,  2'b11},  // R6
    {1'b1, 2'd1, 1'b1, 6'd13, 2'b10},  // R9
    {1'b1, 2'd1, 1'b1, 6'd12, 2'b01},  // R9 hv clear
    {1'b1, 2'd0, 1'b1, 6'd20, 2'b01},  // R3 read-only bit
    {1'b0, 2'd0, 1'b1, 6'd2,  2'b11},  // R5
    {1'b1, 2'd0, 1'b1, 6'd10, 2'b11},  // R7
    {1'b1, 2'd1, 1'b0, 6'd15, 2'b01},  // R8
    {1'b1, 2'd0, 1'b1, 6'd0,  2'b10}   // R9 bit 0
  };

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check2(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic csrWrite(logic [63:0] val);
    @(negedge clk);
    csrWrEn = 1'b1;
    csrWrData = val;
    @(negedge clk);
    csrWrEn = 1'b0;
    #1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check64("R1 reset read", csrRdData, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check64("R1 after release", csrRdData, 64'h0);

    csrWrite('1);
    check64("R2/R3 all ones", csrRdData, 64'h0000_0000_0000_B1FF);
    check64("R4 half alignment bit0", rdHalf, 64'h0000_0000_0000_B1FE);

    csrWrite(64'hFFFF_FFFF_FFFF_4E00);
    check64("R3 read-only bits ignored", csrRdData, 64'h0);

    csrWrite(64'h0000_0000_0000_A0F5);
    check64("R2 pattern", csrRdData, 64'h0000_0000_0000_A0F5);
    @(negedge clk);
    #1;
    check64("R2 hold", csrRdData, 64'h0000_0000_0000_A0F5);

    medelegMask = 64'h0000_0000_0010_B0F7;
    foreach (VEC[i]) begin
      @(negedge clk);
      {trapValid, privLevel, virtMode, trapCause} = VEC[i][11:2];
      #1;
      check2($sformatf("R5-R9 vector %0d", i), targetLevel, VEC[i][1:0]);
    end

    // R10: clear bit 2 in the same cycle as a trap on cause 2
    @(negedge clk);
    trapValid = 1'b1; privLevel = 2'd0; virtMode = 1'b1; trapCause = 6'd2;
    csrWrEn = 1'b1; csrWrData = 64'h0;
    #1;
    check2("R10 old value before edge", targetLevel, 2'b10);
    @(negedge clk);
    csrWrEn = 1'b0;
    #1;
    check2("R10 new value after edge", targetLevel, 2'b01);

    // R10: set bit 12 with a trap on cause 12 in the same cycle
    @(negedge clk);
    trapCause = 6'd12;
    csrWrEn = 1'b1; csrWrData = 64'h0000_0000_0000_1000;
    #1;
    check2("R10 set not yet seen", targetLevel, 2'b01);
    @(negedge clk);
    csrWrEn = 1'b0;
    #1;
    check2("R10 set seen after edge", targetLevel, 2'b10);

    // R6 with bits all set still M
    privLevel = 2'd3;
    #1;
    check2("R6 machine mode", targetLevel, 2'b11);
    trapValid = 1'b0;
    #1;
    check2("R5 idle", targetLevel, 2'b11);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule